// File: doc/BRIEF.md
# Quad DAC Command Register Controller

This block is the host-facing register front end of a four-channel digital-to-analog converter. Every channel keeps two stages of state for both its output range (span) and its output code: an input stage that the host loads, and an active stage that drives the converter. The host places a 16-bit value in a low data byte and a high data byte. It then writes a command byte. The upper nibble of the command selects the operation and bits 2:1 select the channel.

The operations load a span or a code into the input stage, copy the input stage into the active stage, or do both in one command. The copy can cover the addressed channel or every channel. Four readback operations return a stored value through the two data bytes. A status byte shows when the last command has completed. The active stage of every channel is presented in parallel on output ports, ready for a converter link that sits outside this block.

Top module: `quad_dac_regs`

## Requirements
- R1: After reset, all input and active spans and codes are zero, both data bytes read zero, and status reads 0x80 (ready).
- R2: Offset 0 holds the low data byte and offset 1 holds the high data byte, and each reads back what was last written to it. Offset 2 takes command bytes and reads 0x00. Offset 3 is status: bit 7 is ready and the other bits read 0.
- R3: Opcode 0x2 (span write) loads the low 4 bits of the low data byte into the input span. Opcode 0x3 (code write) loads {high byte, low byte} into the input code. Neither changes any active value.
- R4: Opcode 0x4 copies both the input span and the input code into the active stage of the addressed channel only.
- R5: Opcode 0x5 copies input to active for every channel, whatever the channel field holds.
- R6: Opcodes 0x6 and 0x7 write the new span (0x6) or the new code (0x7) into the input stage of the addressed channel. In the same cycle they copy that channel's complete input stage, including the new value, into its active stage.
- R7: Opcodes 0x8 and 0x9 write the new span or code to the addressed channel and then update the active stage of every channel.
- R8: The channel number is taken from command bits 2:1. A low nibble of 0xF addresses all four channels for the write and update operations.
- R9: The readback opcodes load the data bytes as follows: 0xA loads the input span, 0xB the input code, 0xC the active span and 0xD the active code. A span is zero-extended to 16 bits. A broadcast low nibble reads channel 3.
- R10: A span occupies the low 4 bits of the low data byte. The upper low-byte bits and the whole high byte have no effect on a span. The codes are 0: 0 to 5 V, 1: 0 to 10 V, 2: ±5 V, 3: ±10 V, 4: ±2.5 V, 5: −2.5 to +7.5 V.
- R11: Ready goes low on the cycle after a command write and stays low for LAT cycles. A command written while ready is low is still executed, and it restarts the wait.
- R12: Opcode 0xF and the unused opcodes 0x0, 0x1 and 0xE change no span, no code and no data byte.
- R13: The active outputs change only on the clock edge that takes a command write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 2 | Register offset (0 low data, 1 high data, 2 command, 3 status) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the register selected by addr |
| ready_o | output | 1 | Command complete, the same as status bit 7 |
| act_span_o | output | NUM_CH*SPAN_W | Active span of every channel, channel 0 in the low bits |
| act_code_o | output | NUM_CH*16 | Active code of every channel, channel 0 in the low bits |

## Verification
The commands are tried in patterns that separate the two stages. A plain write must leave the active outputs alone. Update on one channel and update on all must then differ on the channels that were not addressed. Write-and-update-all must give the addressed channel the fresh value while the other channels take their older input values, which shows that the write happens before the copy. Broadcast writes, broadcast readback, back-to-back commands while busy, and illegal opcodes round out the patterns. Each cycle the active outputs and the ready flag are compared against a behavioural model that keeps both stages in integer arrays.

// File: rtl/quad_dac_pkg.sv
package quad_dac_pkg;

  localparam int CODE_W = 16;

  localparam logic [1:0] REG_LO   = 2'd0;
  localparam logic [1:0] REG_HI   = 2'd1;
  localparam logic [1:0] REG_CMD  = 2'd2;
  localparam logic [1:0] REG_STAT = 2'd3;

  typedef enum logic [3:0] {
    OP_WR_SPAN      = 4'h2,
    OP_WR_CODE      = 4'h3,
    OP_UPD          = 4'h4,
    OP_UPD_ALL      = 4'h5,
    OP_WRS_UPD      = 4'h6,
    OP_WRC_UPD      = 4'h7,
    OP_WRS_UPD_ALL  = 4'h8,
    OP_WRC_UPD_ALL  = 4'h9,
    OP_RB_IN_SPAN   = 4'hA,
    OP_RB_IN_CODE   = 4'hB,
    OP_RB_ACT_SPAN  = 4'hC,
    OP_RB_ACT_CODE  = 4'hD,
    OP_NOP          = 4'hF
  } dac_op_e;

  typedef enum logic [1:0] {
    RB_IN_SPAN  = 2'd0,
    RB_IN_CODE  = 2'd1,
    RB_ACT_SPAN = 2'd2,
    RB_ACT_CODE = 2'd3
  } rb_sel_e;

  typedef struct packed {
    logic    wr_span;
    logic    wr_code;
    logic    upd_sel;
    logic    upd_all;
    logic    rb;
    rb_sel_e rb_sel;
  } op_dec_t;

  // Opcode to action flags; anything not listed is a no-op.
  function automatic op_dec_t decode_op(logic [3:0] op);
    op_dec_t d;
    d = '{wr_span: 1'b0, wr_code: 1'b0, upd_sel: 1'b0, upd_all: 1'b0,
          rb: 1'b0, rb_sel: RB_IN_SPAN};
    case (op)
      OP_WR_SPAN:     d.wr_span = 1'b1;
      OP_WR_CODE:     d.wr_code = 1'b1;
      OP_UPD:         d.upd_sel = 1'b1;
      OP_UPD_ALL:     d.upd_all = 1'b1;
      OP_WRS_UPD:     begin d.wr_span = 1'b1; d.upd_sel = 1'b1; end
      OP_WRC_UPD:     begin d.wr_code = 1'b1; d.upd_sel = 1'b1; end
      OP_WRS_UPD_ALL: begin d.wr_span = 1'b1; d.upd_all = 1'b1; end
      OP_WRC_UPD_ALL: begin d.wr_code = 1'b1; d.upd_all = 1'b1; end
      OP_RB_IN_SPAN:  begin d.rb = 1'b1; d.rb_sel = RB_IN_SPAN;  end
      OP_RB_IN_CODE:  begin d.rb = 1'b1; d.rb_sel = RB_IN_CODE;  end
      OP_RB_ACT_SPAN: begin d.rb = 1'b1; d.rb_sel = RB_ACT_SPAN; end
      OP_RB_ACT_CODE: begin d.rb = 1'b1; d.rb_sel = RB_ACT_CODE; end
      default:        ;
    endcase
    return d;
  endfunction

  // Zero-extend a span to the 16-bit readback word.
  function automatic logic [CODE_W-1:0] span_word(logic [3:0] s);
    return {{(CODE_W-4){1'b0}}, s};
  endfunction

endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import quad_dac_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              cmd_wr,
  input  logic [7:0]        cmd_byte,
  output logic [NUM_CH-1:0] wr_span,
  output logic [NUM_CH-1:0] wr_code,
  output logic [NUM_CH-1:0] upd,
  output logic              rb_fire,
  output rb_sel_e           rb_sel,
  output logic [CH_W-1:0]   rb_ch
);
  op_dec_t           dec;
  logic              bcast;
  logic [CH_W-1:0]   ch;
  logic [NUM_CH-1:0] target;
  logic [NUM_CH-1:0] all_ch;

  always_comb begin
    dec    = decode_op(cmd_byte[7:4]);
    bcast  = (cmd_byte[3:0] == 4'hF);
    ch     = cmd_byte[CH_W:1];
    all_ch = {NUM_CH{1'b1}};
    target = bcast ? all_ch : (NUM_CH'(1) << ch);
    wr_span = (cmd_wr && dec.wr_span) ? target : '0;
    wr_code = (cmd_wr && dec.wr_code) ? target : '0;
    if (cmd_wr && dec.upd_all)      upd = all_ch;
    else if (cmd_wr && dec.upd_sel) upd = target;
    else                            upd = '0;
    rb_fire = cmd_wr && dec.rb;
    rb_sel  = dec.rb_sel;
    rb_ch   = ch;
  end
endmodule

// File: rtl/dac_chan_buf.sv
module dac_chan_buf #(
  parameter int SPAN_W = 4,
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_span,
  input  logic              wr_code,
  input  logic              upd,
  input  logic [SPAN_W-1:0] new_span,
  input  logic [CODE_W-1:0] new_code,
  output logic [SPAN_W-1:0] in_span,
  output logic [CODE_W-1:0] in_code,
  output logic [SPAN_W-1:0] act_span,
  output logic [CODE_W-1:0] act_code
);
  // Write and update in one cycle: the active stage takes the fresh value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_span  <= '0;
      in_code  <= '0;
      act_span <= '0;
      act_code <= '0;
    end else begin
      if (wr_span) in_span <= new_span;
      if (wr_code) in_code <= new_code;
      if (upd) begin
        act_span <= wr_span ? new_span : in_span;
        act_code <= wr_code ? new_code : in_code;
      end
    end
  end
endmodule

// File: rtl/dac_ready_timer.sv
module dac_ready_timer #(
  parameter int LAT = 4,
  localparam int CW = $clog2(LAT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ready
);
  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            remain <= '0;
    else if (start)        remain <= CW'(LAT);
    else if (remain != '0) remain <= remain - 1'b1;
  end

  assign ready = (remain == '0);
endmodule

// File: rtl/quad_dac_regs.sv
module quad_dac_regs
  import quad_dac_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SPAN_W = 4,
  parameter int LAT    = 4,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [1:0]                 addr,
  input  logic [7:0]                 wdata,
  output logic [7:0]                 rdata,
  output logic                       ready_o,
  output logic [NUM_CH*SPAN_W-1:0]   act_span_o,
  output logic [NUM_CH*CODE_W-1:0]   act_code_o
);
  logic [7:0]        lsb_q, msb_q;
  logic              cmd_wr;
  logic [NUM_CH-1:0] wr_span, wr_code, upd;
  logic              rb_fire;
  rb_sel_e           rb_sel;
  logic [CH_W-1:0]   rb_ch;
  logic [CODE_W-1:0] rb_val;

  logic [SPAN_W-1:0] in_span  [NUM_CH];
  logic [CODE_W-1:0] in_code  [NUM_CH];
  logic [SPAN_W-1:0] act_span [NUM_CH];
  logic [CODE_W-1:0] act_code [NUM_CH];

  assign cmd_wr = wr_en && (addr == REG_CMD);

  dac_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
    .cmd_wr  (cmd_wr),
    .cmd_byte(wdata),
    .wr_span (wr_span),
    .wr_code (wr_code),
    .upd     (upd),
    .rb_fire (rb_fire),
    .rb_sel  (rb_sel),
    .rb_ch   (rb_ch)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dac_chan_buf #(.SPAN_W(SPAN_W), .CODE_W(CODE_W)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_span (wr_span[g]),
      .wr_code (wr_code[g]),
      .upd     (upd[g]),
      .new_span(lsb_q[SPAN_W-1:0]),
      .new_code({msb_q, lsb_q}),
      .in_span (in_span[g]),
      .in_code (in_code[g]),
      .act_span(act_span[g]),
      .act_code(act_code[g])
    );
    assign act_span_o[g*SPAN_W +: SPAN_W] = act_span[g];
    assign act_code_o[g*CODE_W +: CODE_W] = act_code[g];
  end

  dac_ready_timer #(.LAT(LAT)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .start(cmd_wr),
    .ready(ready_o)
  );

  always_comb begin
    case (rb_sel)
      RB_IN_SPAN:  rb_val = span_word(4'(in_span[rb_ch]));
      RB_IN_CODE:  rb_val = in_code[rb_ch];
      RB_ACT_SPAN: rb_val = span_word(4'(act_span[rb_ch]));
      default:     rb_val = act_code[rb_ch];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lsb_q <= '0;
      msb_q <= '0;
    end else if (rb_fire) begin
      lsb_q <= rb_val[7:0];
      msb_q <= rb_val[15:8];
    end else if (wr_en && addr == REG_LO) begin
      lsb_q <= wdata;
    end else if (wr_en && addr == REG_HI) begin
      msb_q <= wdata;
    end
  end

  always_comb begin
    case (addr)
      REG_LO:   rdata = lsb_q;
      REG_HI:   rdata = msb_q;
      REG_STAT: rdata = {ready_o, 7'b0};
      default:  rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/quad_dac_regs_chk.sv
module quad_dac_regs_chk #(
  parameter int NUM_CH = 4,
  parameter int SPAN_W = 4,
  parameter int LAT    = 4,
  localparam int CW    = $clog2(LAT + 1)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic [1:0]               addr,
  input logic [7:0]               wdata,
  input logic                     ready_o,
  input logic [NUM_CH*SPAN_W-1:0] act_span_o,
  input logic [NUM_CH*16-1:0]     act_code_o,
  input logic [7:0]               lsb_q,
  input logic [7:0]               msb_q
);
  logic          cmd_seen;
  logic [3:0]    op;
  logic [CW-1:0] since_cmd;

  assign cmd_seen = wr_en && (addr == 2'd2);
  assign op       = wdata[7:4];

  function automatic logic [15:0] code_of(logic [NUM_CH*16-1:0] v, int idx);
    return v[idx*16 +: 16];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since_cmd <= CW'(LAT);
    else if (cmd_seen)           since_cmd <= '0;
    else if (since_cmd != CW'(LAT)) since_cmd <= since_cmd + 1'b1;
  end

  // R11
  busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o == (since_cmd == CW'(LAT)));

  // R11
  cmd_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_seen |=> !ready_o);

  // R13
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_seen |=> ($stable(act_span_o) && $stable(act_code_o)));

  // R12
  noop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_seen && (op == 4'h0 || op == 4'h1 || op == 4'hE || op == 4'hF))
    |=> ($stable(act_span_o) && $stable(act_code_o) && $stable(lsb_q) && $stable(msb_q)));

  // R6
  wr_code_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_seen && op == 4'h7 && wdata[3:0] != 4'hF)
    |=> (code_of(act_code_o, int'($past(wdata[2:1]))) == $past({msb_q, lsb_q})));

  // R9
  span_rb_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_seen && (op == 4'hA || op == 4'hC))
    |=> (msb_q == 8'h00 && lsb_q[7:SPAN_W] == '0));
endmodule

bind quad_dac_regs quad_dac_regs_chk #(
  .NUM_CH(NUM_CH), .SPAN_W(SPAN_W), .LAT(LAT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .addr      (addr),
  .wdata     (wdata),
  .ready_o   (ready_o),
  .act_span_o(act_span_o),
  .act_code_o(act_code_o),
  .lsb_q     (lsb_q),
  .msb_q     (msb_q)
);

// File: tb/quad_dac_regs_bench.sv
`timescale 1ns/1ps
module quad_dac_regs_bench;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic        ready_o;
  logic [15:0] act_span_o;
  logic [63:0] act_code_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // behavioural reference state
  int m_in_span[4], m_in_code[4], m_act_span[4], m_act_code[4];
  int m_lsb, m_msb, m_cnt;

  always #10 clk = ~clk;

  quad_dac_regs #(.NUM_CH(4), .SPAN_W(4), .LAT(LAT)) u_quad_dac_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ready_o(ready_o), .act_span_o(act_span_o), .act_code_o(act_code_o)
  );

  task automatic model_cmd(input int b);
    int op, ch;
    bit bc;
    bit touch[4];
    bit refresh[4];
    op = b / 16;
    ch = (b / 2) % 4;
    bc = (b % 16) == 15;
    for (int i = 0; i < 4; i++) begin
      touch[i]   = bc || (i == ch);
      refresh[i] = ((op == 4 || op == 6 || op == 7) && touch[i]) ||
                   op == 5 || op == 8 || op == 9;
      if (touch[i] && (op == 2 || op == 6 || op == 8)) m_in_span[i] = m_lsb % 16;
      if (touch[i] && (op == 3 || op == 7 || op == 9)) m_in_code[i] = m_msb * 256 + m_lsb;
    end
    for (int i = 0; i < 4; i++)
      if (refresh[i]) begin
        m_act_span[i] = m_in_span[i];
        m_act_code[i] = m_in_code[i];
      end
    if (op >= 10 && op <= 13) begin
      int v;
      case (op)
        10: v = m_in_span[ch];
        11: v = m_in_code[ch];
        12: v = m_act_span[ch];
        default: v = m_act_code[ch];
      endcase
      m_lsb = v % 256;
      m_msb = v / 256;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_in_span[i] = 0; m_in_code[i] = 0; m_act_span[i] = 0; m_act_code[i] = 0;
      end
      m_lsb = 0; m_msb = 0; m_cnt = 0;
    end else begin
      if (wr_en && addr == 2'd2) m_cnt = LAT;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (wr_en) begin
        case (addr)
          2'd0: m_lsb = wdata;
          2'd1: m_msb = wdata;
          2'd2: model_cmd(wdata);
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison of active outputs and ready against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int i = 0; i < 4; i++) begin
        checks++;
        if (int'(act_span_o[i*4 +: 4]) != m_act_span[i] ||
            int'(act_code_o[i*16 +: 16]) != m_act_code[i]) begin
          fails++;
          $display("FAIL R13 ch%0d: got span %0h code %h expected span %0h code %h",
                   i, act_span_o[i*4 +: 4], act_code_o[i*16 +: 16],
                   m_act_span[i], m_act_code[i]);
        end
      end
      checks++;
      if (ready_o != (m_cnt == 0)) begin
        fails++;
        $display("FAIL R11 ready: got %0b expected %0b", ready_o, m_cnt == 0);
      end
    end
  end

  task automatic check(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_reg(input logic [1:0] a, input int exp, input string tag);
    addr = a;
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic readback(input logic [7:0] cmd, input int exp, input string tag);
    wr(2'd2, cmd);
    expect_reg(2'd0, exp % 256, tag);
    expect_reg(2'd1, exp / 256, tag);
  endtask

  initial begin
    #(20.0 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_reg(2'd3, 8'h80, "R1 status");
    expect_reg(2'd0, 0, "R1 lsb");
    expect_reg(2'd1, 0, "R1 msb");
    check("R1 act", {act_span_o, act_code_o}, 0);
    repeat (LAT) @(negedge clk);
    readback(8'hD6, 0, "R1 act code ch3");
    repeat (LAT) @(negedge clk);

    // R2 data bytes and command offset
    wr(2'd0, 8'h34); wr(2'd1, 8'h12);
    expect_reg(2'd0, 8'h34, "R2 lsb");
    expect_reg(2'd1, 8'h12, "R2 msb");
    expect_reg(2'd2, 8'h00, "R2 cmd reads zero");

    // R3 code write to ch1, R11 ready window
    wr(2'd2, 8'h32);
    expect_reg(2'd3, 8'h00, "R11 busy after cmd");
    repeat (LAT - 1) @(negedge clk);
    expect_reg(2'd3, 8'h00, "R11 still busy");
    @(negedge clk);
    expect_reg(2'd3, 8'h80, "R11 ready after LAT");
    check("R3 act code ch1 untouched", act_code_o[31:16], 0);
    readback(8'hB2, 16'h1234, "R9 input code ch1");
    readback(8'hD2, 0, "R3 active code ch1");

    // R10 span from low nibble only
    wr(2'd0, 8'hA3); wr(2'd1, 8'h55); wr(2'd2, 8'h24);
    check("R3 act span ch2 untouched", act_span_o[11:8], 0);
    readback(8'hA4, 16'h0003, "R10 span low nibble");

    // R4 single-channel update
    wr(2'd2, 8'h42);
    check("R4 ch1 code", act_code_o[31:16], 16'h1234);
    check("R4 ch2 span untouched", act_span_o[11:8], 0);

    // R5 update all, channel field ignored
    wr(2'd2, 8'h56);
    check("R5 ch2 span", act_span_o[11:8], 3);

    // R6 write-and-update
    wr(2'd0, 8'hEF); wr(2'd1, 8'hBE); wr(2'd2, 8'h70);
    check("R6 ch0 code", act_code_o[15:0], 16'hBEEF);
    readback(8'hB0, 16'hBEEF, "R6 ch0 input code");
    wr(2'd0, 8'h05); wr(2'd1, 8'h00); wr(2'd2, 8'h66);
    check("R6 ch3 span", act_span_o[15:12], 5);
    check("R6 ch3 code from input", act_code_o[63:48], 0);

    // R7 write one channel, update all
    wr(2'd0, 8'h77); wr(2'd1, 8'h77); wr(2'd2, 8'h36);
    check("R3 ch3 active after plain write", act_code_o[63:48], 0);
    wr(2'd0, 8'h0F); wr(2'd1, 8'h0F); wr(2'd2, 8'h94);
    check("R7 all codes", act_code_o, 64'h7777_0F0F_1234_BEEF);
    check("R7 all spans", act_span_o, 16'h5300);

    // R8 broadcast write then broadcast update
    wr(2'd0, 8'h04); wr(2'd2, 8'h2F);
    check("R8 active spans unchanged", act_span_o, 16'h5300);
    readback(8'hA0, 4, "R8 ch0 input span");
    readback(8'hA6, 4, "R8 ch3 input span");
    wr(2'd2, 8'h4F);
    check("R8 broadcast update", act_span_o, 16'h4444);
    readback(8'hCF, 4, "R9 broadcast readback ch3");

    // R12 no-op and unused opcodes
    wr(2'd0, 8'h11); wr(2'd1, 8'h22);
    wr(2'd2, 8'hF0); wr(2'd2, 8'h00); wr(2'd2, 8'hE2); wr(2'd2, 8'h1A);
    expect_reg(2'd0, 8'h11, "R12 lsb kept");
    expect_reg(2'd1, 8'h22, "R12 msb kept");
    check("R12 codes kept", act_code_o, 64'h7777_0F0F_1234_BEEF);
    check("R12 spans kept", act_span_o, 16'h4444);
    readback(8'hB2, 16'h1234, "R12 input code kept");

    // R11 back-to-back commands while busy
    wr(2'd0, 8'h01); wr(2'd1, 8'h00); wr(2'd2, 8'h30); wr(2'd2, 8'h40);
    expect_reg(2'd3, 8'h00, "R11 busy after second cmd");
    check("R11 second cmd executed", act_code_o[15:0], 16'h0001);
    repeat (LAT) @(negedge clk);
    expect_reg(2'd3, 8'h80, "R11 ready again");

    // R1 reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 act after reset", {act_span_o, act_code_o}, 0);
    expect_reg(2'd3, 8'h80, "R1 status after reset");
    readback(8'hB0, 0, "R1 input code after reset");
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule